// File: doc/BRIEF.md
# E1 Timeslot-0 Spare Bit Inserter

This block builds timeslot 0 of an outgoing E1 bit stream. It runs at one bit per clock. A framer upstream supplies the position of the current bit: whether the frame is the alignment frame or the non-alignment frame of its double frame, the timeslot number, and the bit position within the timeslot. The block also receives the serial data stream and an external link input. Outside timeslot 0 the serial data passes straight through a single output register.

Inside timeslot 0 the block picks each bit from one of several sources:

- two host byte registers, one for the alignment frame and one for the non-alignment frame;
- the link input, chosen separately for each of the five spare (Sa) positions;
- the serial input;
- an override value from a separate CRC-4 / E-bit generator.

The host registers are copied into shadow copies once per double frame. A sticky flag then tells the host that it may write the next values. If the host does not write in time, the old contents are sent again.

Bit position 0 is the first bit sent in a timeslot and carries the international (Si) bit. A register byte is sent MSB first, so bit position p carries register bit [7-p].

Top module: `e1_ts0_inserter`

## Requirements
- R1: When `ts_i` is not 0, `ser_o` equals the value `ser_i` had one clock earlier.
- R2: In an alignment frame (`frm_odd_i`=0), timeslot-0 positions 1 to 7 send alignment shadow bits [6:0], in that order.
- R3: In a non-alignment frame (`frm_odd_i`=1), timeslot-0 positions 1 and 2 send non-alignment shadow bits [6] and [5].
- R4: Positions 3 to 7 of a non-alignment frame are Sa4 to Sa8, controlled by `sa_sel_i` bits [0] to [4]. A set select bit sends `link_i` and a clear select bit sends non-alignment shadow bit [7-p]. With all five bits set and `link_i` equal to `ser_i`, the Sa bits pass through unaltered.
- R5: `link_req_o` is high only in timeslot 0 of a non-alignment frame, at a Sa position whose select bit is set. It is low everywhere else.
- R6: The Si bit (position 0) follows a fixed priority. If `crc4_en_i` or `ebit_en_i` is high, it is `ovr_bit_i`. Otherwise, if `si_reg_en_i` is 0, it is `ser_i`. Otherwise it is bit [7] of the shadow for the current frame type.
- R7: Both shadows load from the host inputs in the cycle at alignment frame, timeslot 0, position 0. That cycle's bit already uses the new values. Host writes at any other time do not affect the output until the next such cycle, so unrefreshed data is sent again.
- R8: `taf_flag_o` is high from the clock after each shadow load until a clock at which `taf_clr_i` is high. A load and a clear in the same cycle leave the flag set.
- R9: While `rst_ni` is low, `ser_o`, `taf_flag_o`, and both shadows are 0.
- R10: Each output bit is registered, one clock after the position inputs that select it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frm_odd_i | input | 1 | 0 = alignment frame, 1 = non-alignment frame |
| ts_i | input | TS_W | Timeslot number of the current bit |
| bit_i | input | 3 | Bit position within the timeslot, 0 sent first |
| ser_i | input | 1 | Serial data input |
| link_i | input | 1 | External link data for selected Sa positions |
| af_reg_i | input | 8 | Host alignment-frame byte |
| naf_reg_i | input | 8 | Host non-alignment-frame byte |
| sa_sel_i | input | 5 | Per-Sa link select, bit 0 = Sa4 |
| si_reg_en_i | input | 1 | 1 = Si from register, 0 = Si from serial input |
| crc4_en_i | input | 1 | CRC-4 mode, Si taken from override value |
| ebit_en_i | input | 1 | Automatic E-bit insertion, Si taken from override value |
| ovr_bit_i | input | 1 | Si value from CRC-4 / E-bit generator |
| taf_clr_i | input | 1 | Clears the reload flag |
| ser_o | output | 1 | Serial data output, registered |
| link_req_o | output | 1 | Link data strobe for selected Sa positions |
| taf_flag_o | output | 1 | Sticky flag, shadows just loaded |

## Verification
The assertions assume the position inputs describe a legal E1 position: `bit_i` runs 0 to 7 and timeslot 0 is marked by `ts_i`=0. They also assume that the override value, the link data and the serial data for a bit are presented in the same cycle as that bit's position. The bench always drives a complete, consistent position together with its data, one bit per clock at the falling edge. It compares against a shadow model that loads only at the double-frame start.

// File: rtl/e1_ts0_pkg.sv
package e1_ts0_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SA_N     = 5;
  localparam int unsigned SA_FIRST = 3;
  localparam int unsigned POS_W    = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] ts0_byte_t;
endpackage

// File: rtl/e1_ts0_pos_dec.sv
module e1_ts0_pos_dec
  import e1_ts0_pkg::*;
#(
  parameter int unsigned TS_W = 5
) (
  input  logic             frm_odd_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [POS_W-1:0] bit_i,
  output logic             ts0_o,
  output logic             si_o,
  output logic             dbl_start_o,
  output logic [SA_N-1:0]  sa_hit_o
);
  assign ts0_o       = (ts_i == '0);
  assign si_o        = ts0_o && (bit_i == '0);
  assign dbl_start_o = si_o && !frm_odd_i;

  for (genvar g = 0; g < SA_N; g++) begin : g_sa
    assign sa_hit_o[g] = ts0_o && frm_odd_i && (bit_i == POS_W'(SA_FIRST + g));
  end
endmodule

// File: rtl/e1_ts0_shadow.sv
module e1_ts0_shadow
  import e1_ts0_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      clr_i,
  input  ts0_byte_t af_i,
  input  ts0_byte_t naf_i,
  output ts0_byte_t af_eff_o,
  output ts0_byte_t naf_eff_o,
  output logic      flag_o
);
  ts0_byte_t af_q, naf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      af_q   <= '0;
      naf_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (load_i) begin
        af_q  <= af_i;
        naf_q <= naf_i;
      end
      if (load_i)     flag_o <= 1'b1;   // set wins over clear
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  // bit sent at the load position already sees the fresh bytes
  assign af_eff_o  = load_i ? af_i  : af_q;
  assign naf_eff_o = load_i ? naf_i : naf_q;
endmodule

// File: rtl/e1_ts0_bit_sel.sv
module e1_ts0_bit_sel
  import e1_ts0_pkg::*;
(
  input  logic             frm_odd_i,
  input  logic             ts0_i,
  input  logic             si_i,
  input  logic [SA_N-1:0]  sa_hit_i,
  input  logic [POS_W-1:0] bit_i,
  input  logic             ser_i,
  input  logic             link_i,
  input  logic [SA_N-1:0]  sa_sel_i,
  input  logic             si_reg_en_i,
  input  logic             crc4_en_i,
  input  logic             ebit_en_i,
  input  logic             ovr_bit_i,
  input  ts0_byte_t        af_i,
  input  ts0_byte_t        naf_i,
  output logic             nxt_o,
  output logic             link_req_o
);
  ts0_byte_t        reg_byte;
  logic [POS_W-1:0] idx;
  logic             reg_bit;

  assign link_req_o = |(sa_hit_i & sa_sel_i);
  assign reg_byte   = frm_odd_i ? naf_i : af_i;
  assign idx        = POS_W'(BYTE_W - 1) - bit_i;
  assign reg_bit    = reg_byte[idx];

  always_comb begin
    if (!ts0_i)                      nxt_o = ser_i;
    else if (si_i) begin
      if (crc4_en_i || ebit_en_i)    nxt_o = ovr_bit_i;
      else if (!si_reg_en_i)         nxt_o = ser_i;
      else                           nxt_o = reg_bit;
    end
    else if (link_req_o)             nxt_o = link_i;
    else                             nxt_o = reg_bit;
  end
endmodule

// File: rtl/e1_ts0_inserter.sv
module e1_ts0_inserter
  import e1_ts0_pkg::*;
#(
  parameter int unsigned TS_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frm_odd_i,
  input  logic [TS_W-1:0]  ts_i,
  input  logic [POS_W-1:0] bit_i,
  input  logic             ser_i,
  input  logic             link_i,
  input  logic [BYTE_W-1:0] af_reg_i,
  input  logic [BYTE_W-1:0] naf_reg_i,
  input  logic [SA_N-1:0]  sa_sel_i,
  input  logic             si_reg_en_i,
  input  logic             crc4_en_i,
  input  logic             ebit_en_i,
  input  logic             ovr_bit_i,
  input  logic             taf_clr_i,
  output logic             ser_o,
  output logic             link_req_o,
  output logic             taf_flag_o
);
  logic            ts0, si, dbl_start, nxt;
  logic [SA_N-1:0] sa_hit;
  ts0_byte_t       af_eff, naf_eff;

  e1_ts0_pos_dec #(.TS_W(TS_W)) u_dec (
    .frm_odd_i  (frm_odd_i),
    .ts_i       (ts_i),
    .bit_i      (bit_i),
    .ts0_o      (ts0),
    .si_o       (si),
    .dbl_start_o(dbl_start),
    .sa_hit_o   (sa_hit)
  );

  e1_ts0_shadow u_shd (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (dbl_start),
    .clr_i    (taf_clr_i),
    .af_i     (af_reg_i),
    .naf_i    (naf_reg_i),
    .af_eff_o (af_eff),
    .naf_eff_o(naf_eff),
    .flag_o   (taf_flag_o)
  );

  e1_ts0_bit_sel u_sel (
    .frm_odd_i  (frm_odd_i),
    .ts0_i      (ts0),
    .si_i       (si),
    .sa_hit_i   (sa_hit),
    .bit_i      (bit_i),
    .ser_i      (ser_i),
    .link_i     (link_i),
    .sa_sel_i   (sa_sel_i),
    .si_reg_en_i(si_reg_en_i),
    .crc4_en_i  (crc4_en_i),
    .ebit_en_i  (ebit_en_i),
    .ovr_bit_i  (ovr_bit_i),
    .af_i       (af_eff),
    .naf_i      (naf_eff),
    .nxt_o      (nxt),
    .link_req_o (link_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ser_o <= 1'b0;
    else         ser_o <= nxt;
  end
endmodule

// File: rtl/e1_ts0_inserter_chk.sv
module e1_ts0_inserter_chk #(
  parameter int unsigned TS_W = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            frm_odd_i,
  input logic [TS_W-1:0] ts_i,
  input logic [2:0]      bit_i,
  input logic            ser_i,
  input logic            link_i,
  input logic            crc4_en_i,
  input logic            ebit_en_i,
  input logic            ovr_bit_i,
  input logic            taf_clr_i,
  input logic            ser_o,
  input logic            link_req_o,
  input logic            taf_flag_o
);
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_i != '0) |=> (ser_o == $past(ser_i)));                                   // R1
  AST_LINK_SA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_req_o |=> (ser_o == $past(link_i)));                                    // R4
  AST_REQ_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_req_o |-> (ts_i == '0 && frm_odd_i && bit_i >= 3'd3));                  // R5
  AST_SI_OVERRIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_i == '0 && bit_i == 3'd0 && (crc4_en_i || ebit_en_i))
      |=> (ser_o == $past(ovr_bit_i)));                                          // R6
  AST_FLAG_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ts_i == '0 && bit_i == 3'd0 && !frm_odd_i) |=> taf_flag_o);                 // R8
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (taf_flag_o && !taf_clr_i) |=> taf_flag_o);                                  // R8
endmodule

bind e1_ts0_inserter e1_ts0_inserter_chk #(.TS_W(TS_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frm_odd_i (frm_odd_i),
  .ts_i      (ts_i),
  .bit_i     (bit_i),
  .ser_i     (ser_i),
  .link_i    (link_i),
  .crc4_en_i (crc4_en_i),
  .ebit_en_i (ebit_en_i),
  .ovr_bit_i (ovr_bit_i),
  .taf_clr_i (taf_clr_i),
  .ser_o     (ser_o),
  .link_req_o(link_req_o),
  .taf_flag_o(taf_flag_o)
);

// File: tb/e1_ts0_inserter_tb.sv
module e1_ts0_inserter_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       frm_odd_i, ser_i, link_i, si_reg_en_i, crc4_en_i, ebit_en_i, ovr_bit_i, taf_clr_i;
  logic [4:0] ts_i;
  logic [2:0] bit_i;
  logic [7:0] af_reg_i, naf_reg_i;
  logic [4:0] sa_sel_i;
  logic       ser_o, link_req_o, taf_flag_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [7:0] m_af = '0, m_naf = '0;

  always #10 clk_i = ~clk_i;

  e1_ts0_inserter u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .frm_odd_i(frm_odd_i), .ts_i(ts_i), .bit_i(bit_i),
    .ser_i(ser_i), .link_i(link_i), .af_reg_i(af_reg_i), .naf_reg_i(naf_reg_i),
    .sa_sel_i(sa_sel_i), .si_reg_en_i(si_reg_en_i), .crc4_en_i(crc4_en_i),
    .ebit_en_i(ebit_en_i), .ovr_bit_i(ovr_bit_i), .taf_clr_i(taf_clr_i),
    .ser_o(ser_o), .link_req_o(link_req_o), .taf_flag_o(taf_flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // drive one bit position at a falling edge, check strobe now and output one clock later
  task automatic run_pos(input logic odd, input logic [4:0] ts, input logic [2:0] p,
                         input logic sb, input logic lb, input string req);
    logic e, er;
    int   sa;
    bit   bnd;
    frm_odd_i = odd; ts_i = ts; bit_i = p; ser_i = sb; link_i = lb;
    bnd = (!odd && ts == 0 && p == 0);
    if (bnd) begin m_af = af_reg_i; m_naf = naf_reg_i; end
    sa = int'(p) - 3;
    er = odd && ts == 0 && sa >= 0 && sa_sel_i[sa];
    if (ts != 0)                      e = sb;
    else if (p == 0) begin
      if (crc4_en_i || ebit_en_i)     e = ovr_bit_i;
      else if (!si_reg_en_i)          e = sb;
      else                            e = odd ? m_naf[7] : m_af[7];
    end
    else if (er)                      e = lb;
    else                              e = odd ? m_naf[7-p] : m_af[7-p];
    #2;
    chk(link_req_o === er, "R5 link_req_o", int'(link_req_o), int'(er));
    @(negedge clk_i);
    chk(ser_o === e, req, int'(ser_o), int'(e));
    if (bnd) chk(taf_flag_o === 1'b1, "R8 flag after load", int'(taf_flag_o), 1);
  endtask

  task automatic run_ts0(input logic odd, input logic [7:0] sbyte, input logic [7:0] lbyte,
                         input string req);
    for (int p = 0; p < 8; p++) run_pos(odd, 5'd0, 3'(p), sbyte[7-p], lbyte[7-p], req);
  endtask

  task automatic t_reset;
    chk(ser_o === 1'b0, "R9 ser_o in reset", int'(ser_o), 0);
    chk(taf_flag_o === 1'b0, "R9 flag in reset", int'(taf_flag_o), 0);
  endtask

  task automatic t_reset_shadow;
    // non-alignment frame before any load must send zeroed shadow bits
    sa_sel_i = '0;
    run_ts0(1'b1, 8'h00, 8'hFF, "R9 shadow zero after reset");
  endtask

  task automatic t_passthru;
    logic [15:0] pat = 16'hB36D;
    for (int i = 0; i < 16; i++)
      run_pos(i[0], 5'(1 + i), 3'(i % 8), pat[i], ~pat[i], "R1 passthrough");
    run_pos(1'b1, 5'd31, 3'd4, 1'b1, 1'b0, "R10 passthrough latency");
  endtask

  task automatic t_align;
    af_reg_i = 8'h9B; naf_reg_i = 8'h5A; si_reg_en_i = 1'b1;
    run_ts0(1'b0, 8'h00, 8'hFF, "R2 alignment frame");
    run_ts0(1'b1, 8'hFF, 8'h00, "R3 non-alignment frame");
  endtask

  task automatic t_sa_select;
    sa_sel_i = 5'b10101;
    run_ts0(1'b0, 8'h3C, 8'h00, "R2 alignment ignores sa_sel");
    run_ts0(1'b1, 8'h00, 8'hFF, "R4 mixed Sa select");
    sa_sel_i = 5'b01010;
    run_ts0(1'b1, 8'h00, 8'hA5, "R4 mixed Sa select alt");
    sa_sel_i = 5'b11111;
    run_ts0(1'b1, 8'h6B, 8'h6B, "R4 Sa transparent, link tied to serial");
    sa_sel_i = '0;
  endtask

  task automatic t_si_prio;
    af_reg_i = 8'h80; naf_reg_i = 8'h00;
    si_reg_en_i = 1'b0;
    run_pos(1'b0, 5'd0, 3'd0, 1'b0, 1'b1, "R6 Si from serial (0)");
    run_pos(1'b1, 5'd0, 3'd0, 1'b1, 1'b0, "R6 Si from serial (1)");
    crc4_en_i = 1'b1; ovr_bit_i = 1'b1;
    run_pos(1'b1, 5'd0, 3'd0, 1'b0, 1'b0, "R6 CRC-4 override beats serial");
    si_reg_en_i = 1'b1; ovr_bit_i = 1'b0;
    run_pos(1'b0, 5'd0, 3'd0, 1'b1, 1'b1, "R6 CRC-4 override beats register");
    crc4_en_i = 1'b0; ebit_en_i = 1'b1; ovr_bit_i = 1'b1;
    run_pos(1'b1, 5'd0, 3'd0, 1'b0, 1'b0, "R6 E-bit override");
    ebit_en_i = 1'b0;
    run_pos(1'b0, 5'd0, 3'd0, 1'b0, 1'b0, "R6 Si from register");
  endtask

  task automatic t_stale;
    af_reg_i = 8'hC3; naf_reg_i = 8'h99;
    run_ts0(1'b0, 8'h00, 8'h00, "R7 load at double-frame start");
    af_reg_i = 8'h11; naf_reg_i = 8'h66;     // written mid double frame
    run_ts0(1'b1, 8'h00, 8'h00, "R7 mid-frame write not seen");
    af_reg_i = 8'h12; naf_reg_i = 8'h77;     // change again, but check old value remains
    run_pos(1'b1, 5'd0, 3'd4, 1'b0, 1'b0, "R7 stale NAF bit");
    chk(m_naf === 8'h99, "R7 model shadow held", int'(m_naf), 8'h99);
    run_ts0(1'b0, 8'h00, 8'h00, "R7 new values at next boundary");
    run_ts0(1'b1, 8'h00, 8'h00, "R7 new NAF values");
  endtask

  task automatic t_flag;
    taf_clr_i = 1'b1;
    @(negedge clk_i);
    taf_clr_i = 1'b0;
    chk(taf_flag_o === 1'b0, "R8 clear", int'(taf_flag_o), 0);
    run_pos(1'b1, 5'd0, 3'd1, 1'b0, 1'b0, "R3 position 1");
    chk(taf_flag_o === 1'b0, "R8 no set outside boundary", int'(taf_flag_o), 0);
    run_pos(1'b0, 5'd0, 3'd0, 1'b0, 1'b0, "R8 boundary sets flag");
    repeat (3) @(negedge clk_i);
    chk(taf_flag_o === 1'b1, "R8 sticky", int'(taf_flag_o), 1);
    taf_clr_i = 1'b1;
    run_pos(1'b0, 5'd0, 3'd0, 1'b0, 1'b0, "R8 set wins over clear");
    taf_clr_i = 1'b0;
  endtask

  initial begin
    #4ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    frm_odd_i = 1'b0; ts_i = 5'd3; bit_i = '0; ser_i = 1'b1; link_i = 1'b1;
    af_reg_i = 8'hFF; naf_reg_i = 8'hFF; sa_sel_i = '0;
    si_reg_en_i = 1'b1; crc4_en_i = 1'b0; ebit_en_i = 1'b0; ovr_bit_i = 1'b0; taf_clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    t_reset;
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_shadow;
    t_passthru;
    t_align;
    t_sa_select;
    t_si_prio;
    t_stale;
    t_flag;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule